// File: doc/BRIEF.md
# Remote Reconfiguration Register Bank

This block is the register set that sits behind a remote-upgrade controller in a reconfigurable device. User logic talks to it through a serial shift chain clocked by the user clock. It can capture a register into the chain, shift bits in and out, and commit the chain into an update register. A 38-bit control register and a 5-bit status register live in a slow oscillator clock domain. On a reconfiguration request, the control register takes the update register's contents, and the status register records why the reload happened.

The image flag in the control register decides how capture and update behave. Under the factory image, capture reads the update register and updates are accepted. Under an application image, capture reads the control register and updates are dropped. Requests cross between the two domains as toggles through synchronizer chains. While one reconfiguration is in flight, new update and reload requests are refused. This keeps the update register and the cause stable while the oscillator domain reads them.

Top module: `rcfg_reg_bank`

## Requirements
- R1: After reset, all of the following hold: the control register is zero (factory image, watchdog off, page zero), the update register is zero and the status register is zero. A capture of either source therefore shifts out all zeros.
- R2: The control word has these fields: bits 37..26 are the 12-bit watchdog timeout, bit 25 is the watchdog enable, bits 24..1 are the 24-bit page address, and bit 0 is the image flag (1 = application, 0 = factory). Each field is kept intact through an update and a reload.
- R3: On each user-clock cycle with shift enable set (and no capture or update), the chain moves one bit toward bit 0. Serial in enters bit 37 and serial out always shows bit 0, so words travel LSB first.
- R4: Capture takes priority over update, and update takes priority over shift. Only the highest-priority strobe asserted in a cycle acts.
- R5: The capture source is chosen as follows. With the status select high, capture loads the status register into chain bits 4..0 and zeros above. With the status select low, capture loads the update register under the factory image and the control register under an application image.
- R6: Under the factory image, update copies the whole shift chain into the update register. Under an application image, update leaves the update register unchanged.
- R7: An accepted reload copies the update register into the control register and the cause into the status register. The result is visible to a capture within 60 user-clock cycles when the oscillator clock is at least one fifth of the user clock.
- R8: The cause is one-hot with these bits: bit 0 external configuration request, bit 1 watchdog timeout, bit 2 configuration CRC error, bit 3 configuration error pin, bit 4 user-logic request. The status register never holds more than one set bit.
- R9: A reload is in flight from the cycle it is accepted until its results reach the user domain. During that time, update strobes and further reload strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk | input | 1 | User clock for the shift chain and update register |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| shift_en | input | 1 | Advance the shift chain by one bit |
| sdi | input | 1 | Serial data into chain bit 37 |
| capture | input | 1 | Load the selected register into the chain |
| cap_status | input | 1 | Capture source select: 1 status, 0 configuration |
| update | input | 1 | Commit the chain to the update register |
| reload | input | 1 | Reconfiguration request pulse (user clock) |
| reload_cause | input | 5 | One-hot cause of the reconfiguration |
| oclk | input | 1 | Internal oscillator clock for control and status |
| sdo | output | 1 | Serial data out, chain bit 0 |

## Verification
The hardest state to reach is a reload that is still in flight while new strobes arrive. A full serial word takes longer to shift in than the handshake takes to finish. To hit this window, the bench preloads the chain, then fires a reload, an update and a second reload on three consecutive cycles. It then checks that neither the first update register contents nor the first cause were overwritten. Telling the two capture sources apart takes a second setup step. Under the factory image, the bench changes the update register after a reload, so that control and update hold different words.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
    localparam int DEF_WD_W        = 12;
    localparam int DEF_PAGE_W      = 24;
    localparam int DEF_CAUSE_W     = 5;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int IMG_BIT         = 0;
endpackage

// File: rtl/rcb_sync.sv
module rcb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rcb_user_side.sv
module rcb_user_side #(
    parameter int CFG_W   = 38,
    parameter int CAUSE_W = 5,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    input  logic               capture,
    input  logic               cap_status,
    input  logic               update,
    input  logic               reload,
    input  logic [CAUSE_W-1:0] reload_cause,
    input  logic               ack_tgl,
    input  logic [CFG_W-1:0]   ctrl_in,
    input  logic [CAUSE_W-1:0] status_in,
    output logic               sdo,
    output logic [CFG_W-1:0]   upd_out,
    output logic [CAUSE_W-1:0] cause_out,
    output logic               req_tgl
);
    import rcb_pkg::*;

    typedef struct packed {
        logic [CFG_W-1:0]   sh;
        logic [CFG_W-1:0]   upd;
        logic [CFG_W-1:0]   ctrl_m;
        logic [CAUSE_W-1:0] stat_m;
        logic [CAUSE_W-1:0] cause;
        logic               req;
        logic               ack_seen;
    } user_st_t;

    user_st_t st_d, st_q;
    logic     ack_s;
    logic     busy;
    logic     app;

    rcb_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign busy = (st_q.req != st_q.ack_seen);
    assign app  = st_q.ctrl_m[IMG_BIT];

    always_comb begin
        st_d = st_q;
        // oscillator-side results arrived: mirror them locally
        if (ack_s != st_q.ack_seen) begin
            st_d.ack_seen = ack_s;
            st_d.ctrl_m   = ctrl_in;
            st_d.stat_m   = status_in;
        end
        if (capture) begin
            if (cap_status)
                st_d.sh = CFG_W'(st_q.stat_m);
            else if (app)
                st_d.sh = st_q.ctrl_m;
            else
                st_d.sh = st_q.upd;
        end else if (update) begin
            if (!app && !busy)
                st_d.upd = st_q.sh;
        end else if (shift_en) begin
            st_d.sh = {sdi, st_q.sh[CFG_W-1:1]};
        end
        if (reload && !busy) begin
            st_d.req   = ~st_q.req;
            st_d.cause = reload_cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo       = st_q.sh[0];
    assign upd_out   = st_q.upd;
    assign cause_out = st_q.cause;
    assign req_tgl   = st_q.req;

    logic [CFG_W-1:0]   sh_w;
    logic [CFG_W-1:0]   upd_w;
    logic [CAUSE_W-1:0] stat_w;
    assign sh_w   = st_q.sh;
    assign upd_w  = st_q.upd;
    assign stat_w = st_q.stat_m;

    p_lsb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture && !update) |=>
            (sh_w[CFG_W-2:0] == $past(sh_w[CFG_W-1:1])) && (sh_w[CFG_W-1] == $past(sdi)));

    p_app_update_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !capture && app) |=> $stable(upd_w));

    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(upd_w));

    p_capture_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && update) |=> $stable(upd_w));

    p_status_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cap_status) |=> (sh_w == CFG_W'($past(stat_w))));
endmodule

// File: rtl/rcb_osc_side.sv
module rcb_osc_side #(
    parameter int CFG_W   = 38,
    parameter int CAUSE_W = 5,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_tgl,
    input  logic [CFG_W-1:0]   upd_in,
    input  logic [CAUSE_W-1:0] cause_in,
    output logic [CFG_W-1:0]   ctrl_out,
    output logic [CAUSE_W-1:0] status_out,
    output logic               ack_tgl
);
    typedef struct packed {
        logic [CFG_W-1:0]   ctrl;
        logic [CAUSE_W-1:0] stat;
        logic               req_seen;
    } osc_st_t;

    osc_st_t st_d, st_q;
    logic    req_s;
    logic    take;

    rcb_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    assign take = (req_s != st_q.req_seen);

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.req_seen = req_s;
            st_d.ctrl     = upd_in;
            st_d.stat     = cause_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_out   = st_q.ctrl;
    assign status_out = st_q.stat;
    assign ack_tgl    = st_q.req_seen;

    logic [CFG_W-1:0]   ctrl_w;
    logic [CAUSE_W-1:0] stat_w;
    assign ctrl_w = st_q.ctrl;
    assign stat_w = st_q.stat;

    p_reload_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ctrl_w == $past(upd_in)));

    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(ctrl_w) && $stable(stat_w));

    p_cause_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_w));
endmodule

// File: rtl/rcfg_reg_bank.sv
module rcfg_reg_bank #(
    parameter int WD_W        = rcb_pkg::DEF_WD_W,
    parameter int PAGE_W      = rcb_pkg::DEF_PAGE_W,
    parameter int CAUSE_W     = rcb_pkg::DEF_CAUSE_W,
    parameter int SYNC_STAGES = rcb_pkg::DEF_SYNC_STAGES
) (
    input  logic               uclk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    input  logic               capture,
    input  logic               cap_status,
    input  logic               update,
    input  logic               reload,
    input  logic [CAUSE_W-1:0] reload_cause,
    input  logic               oclk,
    output logic               sdo
);
    localparam int CFG_W = WD_W + 1 + PAGE_W + 1;

    logic [CFG_W-1:0]   upd_x;
    logic [CFG_W-1:0]   ctrl_x;
    logic [CAUSE_W-1:0] cause_x;
    logic [CAUSE_W-1:0] stat_x;
    logic               req_x;
    logic               ack_x;

    rcb_user_side #(.CFG_W(CFG_W), .CAUSE_W(CAUSE_W), .STAGES(SYNC_STAGES)) u_user (
        .clk          (uclk),
        .rst_n        (rst_n),
        .shift_en     (shift_en),
        .sdi          (sdi),
        .capture      (capture),
        .cap_status   (cap_status),
        .update       (update),
        .reload       (reload),
        .reload_cause (reload_cause),
        .ack_tgl      (ack_x),
        .ctrl_in      (ctrl_x),
        .status_in    (stat_x),
        .sdo          (sdo),
        .upd_out      (upd_x),
        .cause_out    (cause_x),
        .req_tgl      (req_x)
    );

    rcb_osc_side #(.CFG_W(CFG_W), .CAUSE_W(CAUSE_W), .STAGES(SYNC_STAGES)) u_osc (
        .clk        (oclk),
        .rst_n      (rst_n),
        .req_tgl    (req_x),
        .upd_in     (upd_x),
        .cause_in   (cause_x),
        .ctrl_out   (ctrl_x),
        .status_out (stat_x),
        .ack_tgl    (ack_x)
    );
endmodule

// File: tb/rcfg_reg_bank_test.sv
module rcfg_reg_bank_test;
    localparam int W = 38;

    logic       uclk = 1'b0, oclk = 1'b0, rst_n = 1'b0;
    logic       shift_en = 1'b0, sdi = 1'b0, capture = 1'b0, cap_status = 1'b0;
    logic       update = 1'b0, reload = 1'b0;
    logic [4:0] reload_cause = '0;
    logic       sdo;

    rcfg_reg_bank uut (
        .uclk(uclk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi),
        .capture(capture), .cap_status(cap_status), .update(update),
        .reload(reload), .reload_cause(reload_cause), .oclk(oclk), .sdo(sdo)
    );

    always #10 uclk = ~uclk;
    always #50 oclk = ~oclk;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_upd, m_ctrl;
    logic [4:0]   m_stat;

    function automatic logic [W-1:0] model_cfg();
        return m_ctrl[0] ? m_ctrl : m_upd;
    endfunction

    function automatic logic [W-1:0] rand_word(input logic img);
        logic [63:0] r;
        r = {$urandom, $urandom};
        return {r[W-1:1], img};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge uclk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        m_upd = '0; m_ctrl = '0; m_stat = '0;
    endtask

    task automatic shift_in(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) begin
            shift_en = 1'b1; sdi = v[i];
            tick();
        end
        shift_en = 1'b0; sdi = 1'b0;
    endtask

    task automatic read_out(output logic [W-1:0] v);
        for (int i = 0; i < W; i++) begin
            v[i] = sdo;
            shift_en = 1'b1; sdi = 1'b0;
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic cap(input logic st);
        capture = 1'b1; cap_status = st;
        tick();
        capture = 1'b0; cap_status = 1'b0;
    endtask

    task automatic do_update(input logic [W-1:0] chain);
        update = 1'b1;
        tick();
        update = 1'b0;
        if (!m_ctrl[0]) m_upd = chain;
    endtask

    task automatic do_reload(input logic [4:0] c);
        reload = 1'b1; reload_cause = c;
        tick();
        reload = 1'b0; reload_cause = '0;
        m_ctrl = m_upd; m_stat = c;
        repeat (60) tick();
    endtask

    task automatic check_cfg(input string req);
        logic [W-1:0] v;
        cap(1'b0);
        read_out(v);
        chk(req, 64'(v), 64'(model_cfg()));
    endtask

    task automatic check_stat(input string req);
        logic [W-1:0] v;
        cap(1'b1);
        read_out(v);
        chk(req, 64'(v), 64'(m_stat));
    endtask

    initial begin
        repeat (150000) @(posedge uclk);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] v, a, b, rd;
        logic [4:0]   c;
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R1 reset state
        check_cfg("R1 config after reset");
        check_stat("R1 status after reset");

        // R3 LSB-first chain without capture
        a = rand_word(1'b1);
        shift_in(a);
        read_out(rd);
        chk("R3 shift pass-through", 64'(rd), 64'(a));

        // R5/R6 random factory updates
        for (int k = 0; k < 8; k++) begin
            v = rand_word(1'b0);
            shift_in(v);
            do_update(v);
            check_cfg("R6 factory update then R5 capture");
        end

        // R4 capture beats update
        a = rand_word(1'b0);
        shift_in(a); do_update(a);
        b = rand_word(1'b0);
        shift_in(b);
        capture = 1'b1; update = 1'b1;
        tick();
        capture = 1'b0; update = 1'b0;
        read_out(rd);
        chk("R4 capture over update chain", 64'(rd), 64'(a));
        check_cfg("R4 update suppressed by capture");

        // R4 update beats shift
        b = rand_word(1'b0);
        shift_in(b);
        update = 1'b1; shift_en = 1'b1; sdi = 1'b1;
        tick();
        update = 1'b0; shift_en = 1'b0; sdi = 1'b0;
        m_upd = b;
        read_out(rd);
        chk("R4 shift suppressed by update", 64'(rd), 64'(b));
        check_cfg("R4 update over shift");

        // R7/R8 reload under factory image
        for (int k = 0; k < 3; k++) begin
            c = 5'b00001 << ($urandom % 5);
            do_reload(c);
            check_stat("R8 one-hot cause recorded");
            v = rand_word(1'b0);
            shift_in(v); do_update(v);
            check_cfg("R7 factory capture reads new update");
        end

        // R9 strobes ignored while reload in flight
        a = m_upd;
        b = rand_word(1'b0);
        shift_in(b);
        reload = 1'b1; reload_cause = 5'b00100;
        tick();
        reload = 1'b0; update = 1'b1;
        tick();
        update = 1'b0; reload = 1'b1; reload_cause = 5'b10000;
        tick();
        reload = 1'b0; reload_cause = '0;
        m_ctrl = a; m_stat = 5'b00100;
        repeat (60) tick();
        check_cfg("R9 update dropped while busy");
        check_stat("R9 second reload dropped");

        // R2 field layout through an application image
        v = {12'hA5C, 1'b1, 24'h3C5AF0, 1'b1};
        shift_in(v); do_update(v);
        do_reload(5'b00010);
        cap(1'b0);
        read_out(rd);
        chk("R2 watchdog timeout field", 64'(rd[37:26]), 64'(12'hA5C));
        chk("R2 watchdog enable bit", 64'(rd[25]), 64'(1'b1));
        chk("R2 page address field", 64'(rd[24:1]), 64'(24'h3C5AF0));
        chk("R2 image flag", 64'(rd[0]), 64'(1'b1));
        check_stat("R7 status after app reload");

        // R6 update ignored under application image
        b = rand_word(1'b0);
        shift_in(b);
        do_update(b);
        check_cfg("R6 application update ignored");
        do_reload(5'b01000);
        check_cfg("R6 control unchanged after reload");
        check_stat("R8 cause after second app reload");

        // R1 reset again from application image
        do_reset();
        check_cfg("R1 config after second reset");
        check_stat("R1 status after second reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule